// File: doc/BRIEF.md
# Clock-calendar update controller

This block holds a wall-clock and calendar register set (seconds, minutes, hours, weekday, date, month, two-digit year) plus a seconds/minutes/hours alarm. A once-per-second tick starts an update cycle. The block first raises an update-in-progress flag for a fixed lead interval, then runs an update interval, and only at the end of that interval does the whole register set step forward by one second, in a single clock edge. A host that sees the flag clear knows that every field belongs to the same second.

Software reaches all state through an indexed byte port. Writes take effect at the next clock edge and reads are combinational. Two control bytes set the behaviour. One holds the time-base selector. The other holds an inhibit bit that stops updating while the host loads a new time, a binary/BCD selector and a 12/24-hour selector. When an update completes, the block emits a one-cycle completion pulse. If the new seconds, minutes and hours equal the alarm bytes, it also emits an alarm pulse. The lead and update intervals are parameters counted in cycles of the fast clock.

Top module: `rtc_update_ctrl`

## Requirements
- R1: After reset the bytes read: indices 0 to 5 read 0x00, weekday (6), date (7) and month (8) read 0x01, year (9) reads 0x00, control A (10) reads 0x20, control B (11) reads 0x02. Both event outputs are low.
- R2: An accepted tick raises the busy flag, read as bit 7 of index 10, in the cycle after the tick is sampled. The flag stays high for exactly LEAD_CYC+UPD_CYC cycles and clears in the cycle the new time becomes visible.
- R3: No time or date byte changes while the busy flag is high. All advanced fields change together on one edge.
- R4: `upd_done` is high for exactly one cycle, the first cycle after the busy flag falls.
- R5: In 24-hour mode (index 11 bit 1 set), seconds step 59 to 0 and carry into minutes, minutes step 59 to 0 and carry into hours, and hours step 23 to 0 and carry into the day.
- R6: In 12-hour mode (index 11 bit 1 clear), the hours byte holds 1 to 12 in bits 6:0 and a PM marker in bit 7. 11 AM advances to 12 PM, 12 PM to 1 PM, and 11 PM to 12 AM, and only the last of these carries into the day.
- R7: Index 11 bit 2 set keeps all time, date and alarm bytes in plain binary. When it is clear, they are two BCD digits (tens in bits 7:4).
- R8: The weekday cycles 1..7 then back to 1. The date wraps after the month's last day: 30 for months 4, 6, 9 and 11, 28 for month 2 or 29 when the year is divisible by 4, and 31 otherwise. Month 12 wraps to 1 and advances the year, and year 99 wraps to 0.
- R9: While index 11 bit 7 is set, ticks are ignored. Setting it during an update cycle clears the busy flag on the next edge, with no time change and no completion pulse.
- R10: Ticks are accepted only when bits 6:4 of index 10 equal 3'b010. Other values, such as 0x60 or 0x70, ignore ticks.
- R11: `alarm_evt` pulses together with `upd_done` exactly when the new seconds, minutes and hours bytes equal the alarm bytes at indices 1, 3 and 5.
- R12: Indices 0..9 map to seconds, alarm seconds, minutes, alarm minutes, hours, alarm hours, weekday, date, month and year. Bit 7 of index 10 ignores writes, and indices 12..15 read 0.
- R13: A tick arriving while the busy flag is high neither restarts nor extends the cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sec_tick | input | 1 | One-cycle pulse once per second |
| reg_idx | input | 4 | Register index for read and write |
| reg_wr | input | 1 | Write strobe for `reg_wdata` at `reg_idx` |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Combinational read data at `reg_idx` |
| upd_done | output | 1 | One-cycle update-complete pulse |
| alarm_evt | output | 1 | One-cycle alarm-match pulse |

## Verification
A tick sampled at edge P0 makes the busy flag readable one cycle later. The time bytes, the flag clearing and `upd_done` all appear after edge P0+LEAD_CYC+UPD_CYC. The bench drives the tick for one cycle from a falling edge. It checks at the falling edge just before that commit edge that the flag is still high, no pulse has fired and the seconds byte is unchanged. It then checks at the next falling edge that the pulse is present and the new values hold. For inhibit and divider cases it waits past the full cycle length and confirms that the flag, the completion count and the time are all unchanged.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
   localparam int IDX_W  = 4;
   localparam int BYTE_W = 8;

   localparam logic [IDX_W-1:0] IDX_SEC  = 4'd0;
   localparam logic [IDX_W-1:0] IDX_ASEC = 4'd1;
   localparam logic [IDX_W-1:0] IDX_MIN  = 4'd2;
   localparam logic [IDX_W-1:0] IDX_AMIN = 4'd3;
   localparam logic [IDX_W-1:0] IDX_HR   = 4'd4;
   localparam logic [IDX_W-1:0] IDX_AHR  = 4'd5;
   localparam logic [IDX_W-1:0] IDX_WDAY = 4'd6;
   localparam logic [IDX_W-1:0] IDX_DATE = 4'd7;
   localparam logic [IDX_W-1:0] IDX_MON  = 4'd8;
   localparam logic [IDX_W-1:0] IDX_YEAR = 4'd9;
   localparam logic [IDX_W-1:0] IDX_CTLA = 4'd10;
   localparam logic [IDX_W-1:0] IDX_CTLB = 4'd11;

   localparam int CB_HOLD = 7;
   localparam int CB_BIN  = 2;
   localparam int CB_H24  = 1;
   localparam logic [2:0] TB_RUN = 3'b010;

   typedef logic [BYTE_W-1:0] byte_t;

   typedef struct packed {
      byte_t sec;
      byte_t min;
      byte_t hr;
      byte_t wday;
      byte_t date;
      byte_t mon;
      byte_t year;
   } tod_t;

   typedef enum logic [1:0] {SQ_IDLE, SQ_LEAD, SQ_BUSY} seq_st_t;

   function automatic byte_t dec_val(byte_t v, logic bin);
      return bin ? v : byte_t'(byte_t'(v[7:4]) * 8'd10 + byte_t'(v[3:0]));
   endfunction

   function automatic byte_t enc_val(byte_t v, logic bin);
      return bin ? v : byte_t'(((v / 8'd10) << 4) | (v % 8'd10));
   endfunction

   function automatic byte_t month_len(byte_t mon, byte_t year);
      byte_t n;
      case (mon)
         8'd2:                      n = (year[1:0] == 2'b00) ? 8'd29 : 8'd28;
         8'd4, 8'd6, 8'd9, 8'd11:   n = 8'd30;
         default:                   n = 8'd31;
      endcase
      return n;
   endfunction
endpackage

// File: rtl/rtc_seq.sv
module rtc_seq #(
   parameter int LEAD_CYC = 4,
   parameter int UPD_CYC  = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick,
   input  logic run_ok,
   output logic busy,
   output logic commit
);
   import rtc_pkg::*;
   localparam int MAXC  = (LEAD_CYC > UPD_CYC) ? LEAD_CYC : UPD_CYC;
   localparam int CNT_W = $clog2(MAXC) + 1;
   localparam logic [CNT_W-1:0] LEAD_LAST = CNT_W'(LEAD_CYC - 1);
   localparam logic [CNT_W-1:0] UPD_LAST  = CNT_W'(UPD_CYC - 1);

   seq_st_t st_q;
   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q  <= SQ_IDLE;
         cnt_q <= '0;
      end else begin
         case (st_q)
            SQ_IDLE: if (tick && run_ok) begin
               st_q  <= SQ_LEAD;
               cnt_q <= '0;
            end
            SQ_LEAD: if (!run_ok) st_q <= SQ_IDLE;
               else if (cnt_q == LEAD_LAST) begin
                  st_q  <= SQ_BUSY;
                  cnt_q <= '0;
               end else cnt_q <= cnt_q + 1'b1;
            SQ_BUSY: if (!run_ok || cnt_q == UPD_LAST) st_q <= SQ_IDLE;
               else cnt_q <= cnt_q + 1'b1;
            default: st_q <= SQ_IDLE;
         endcase
      end
   end

   assign busy   = (st_q != SQ_IDLE);
   assign commit = (st_q == SQ_BUSY) && run_ok && (cnt_q == UPD_LAST);
endmodule

// File: rtl/rtc_advance.sv
module rtc_advance (
   input  rtc_pkg::tod_t cur,
   input  logic          bin_mode,
   input  logic          h24_mode,
   output rtc_pkg::tod_t nxt
);
   import rtc_pkg::*;
   byte_t s, m, h12, hb, wd, dt, mo, yr, mlen;
   byte_t hb_n, h_mod, h_disp, h_enc;
   logic  s_wrap, m_wrap, h_wrap, d_wrap, mo_wrap;
   logic  c_min, c_hr, c_day, c_mon, c_yr;

   always_comb begin
      s   = dec_val(cur.sec, bin_mode);
      m   = dec_val(cur.min, bin_mode);
      wd  = dec_val(cur.wday, bin_mode);
      dt  = dec_val(cur.date, bin_mode);
      mo  = dec_val(cur.mon, bin_mode);
      yr  = dec_val(cur.year, bin_mode);
      h12 = dec_val({1'b0, cur.hr[6:0]}, bin_mode);
      if (h24_mode) hb = dec_val(cur.hr, bin_mode);
      else hb = ((h12 == 8'd12) ? 8'd0 : h12) + (cur.hr[7] ? 8'd12 : 8'd0);
      mlen = month_len(mo, yr);

      s_wrap  = (s >= 8'd59);
      m_wrap  = (m >= 8'd59);
      h_wrap  = (hb >= 8'd23);
      d_wrap  = (dt >= mlen);
      mo_wrap = (mo >= 8'd12);
      c_min   = s_wrap;
      c_hr    = c_min && m_wrap;
      c_day   = c_hr && h_wrap;
      c_mon   = c_day && d_wrap;
      c_yr    = c_mon && mo_wrap;

      hb_n   = h_wrap ? 8'd0 : hb + 8'd1;
      h_mod  = (hb_n >= 8'd12) ? hb_n - 8'd12 : hb_n;
      h_disp = (h_mod == 8'd0) ? 8'd12 : h_mod;
      h_enc  = enc_val(h_disp, bin_mode);

      nxt = cur;
      nxt.sec = s_wrap ? 8'd0 : enc_val(s + 8'd1, bin_mode);
      if (c_min) nxt.min = m_wrap ? 8'd0 : enc_val(m + 8'd1, bin_mode);
      if (c_hr) begin
         if (h24_mode) nxt.hr = enc_val(hb_n, bin_mode);
         else          nxt.hr = {(hb_n >= 8'd12), h_enc[6:0]};
      end
      if (c_day) begin
         nxt.wday = (wd >= 8'd7) ? 8'd1 : enc_val(wd + 8'd1, bin_mode);
         nxt.date = d_wrap ? 8'd1 : enc_val(dt + 8'd1, bin_mode);
      end
      if (c_mon) nxt.mon  = mo_wrap ? 8'd1 : enc_val(mo + 8'd1, bin_mode);
      if (c_yr)  nxt.year = (yr >= 8'd99) ? 8'd0 : enc_val(yr + 8'd1, bin_mode);
   end
endmodule

// File: rtl/rtc_alarm_cmp.sv
module rtc_alarm_cmp #(
   parameter int N_FIELDS = 3,
   parameter int FIELD_W  = 8
) (
   input  logic [N_FIELDS*FIELD_W-1:0] now_v,
   input  logic [N_FIELDS*FIELD_W-1:0] alm_v,
   output logic                        hit
);
   logic [N_FIELDS-1:0] eq;
   for (genvar i = 0; i < N_FIELDS; i++) begin : g_field
      assign eq[i] = (now_v[i*FIELD_W +: FIELD_W] == alm_v[i*FIELD_W +: FIELD_W]);
   end
   assign hit = &eq;
endmodule

// File: rtl/rtc_update_ctrl.sv
module rtc_update_ctrl #(
   parameter int LEAD_CYC = 4,
   parameter int UPD_CYC  = 8
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       sec_tick,
   input  logic [3:0] reg_idx,
   input  logic       reg_wr,
   input  logic [7:0] reg_wdata,
   output logic [7:0] reg_rdata,
   output logic       upd_done,
   output logic       alarm_evt
);
   import rtc_pkg::*;

   if (LEAD_CYC < 1) begin : g_bad_lead
      $error("LEAD_CYC must be at least 1");
   end
   if (UPD_CYC < 1) begin : g_bad_upd
      $error("UPD_CYC must be at least 1");
   end

   tod_t       tod_q, tod_nxt;
   byte_t      alm_s_q, alm_m_q, alm_h_q;
   logic [6:0] ctla_q;
   byte_t      ctlb_q;
   logic       run_ok, uip, commit, alarm_hit;

   assign run_ok = !ctlb_q[CB_HOLD] && (ctla_q[6:4] == TB_RUN);

   rtc_seq #(.LEAD_CYC(LEAD_CYC), .UPD_CYC(UPD_CYC)) u_seq (
      .clk(clk), .rst_n(rst_n), .tick(sec_tick), .run_ok(run_ok),
      .busy(uip), .commit(commit)
   );

   rtc_advance u_adv (
      .cur(tod_q), .bin_mode(ctlb_q[CB_BIN]), .h24_mode(ctlb_q[CB_H24]), .nxt(tod_nxt)
   );

   rtc_alarm_cmp #(.N_FIELDS(3), .FIELD_W(BYTE_W)) u_alm (
      .now_v({tod_nxt.hr, tod_nxt.min, tod_nxt.sec}),
      .alm_v({alm_h_q, alm_m_q, alm_s_q}),
      .hit(alarm_hit)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tod_q     <= '{sec: 8'd0, min: 8'd0, hr: 8'd0, wday: 8'd1,
                        date: 8'd1, mon: 8'd1, year: 8'd0};
         alm_s_q   <= '0;
         alm_m_q   <= '0;
         alm_h_q   <= '0;
         ctla_q    <= 7'h20;
         ctlb_q    <= 8'h02;
         upd_done  <= 1'b0;
         alarm_evt <= 1'b0;
      end else begin
         upd_done  <= commit;
         alarm_evt <= commit && alarm_hit;
         if (commit) tod_q <= tod_nxt;
         if (reg_wr) begin
            case (reg_idx)
               IDX_SEC:  tod_q.sec  <= reg_wdata;
               IDX_ASEC: alm_s_q    <= reg_wdata;
               IDX_MIN:  tod_q.min  <= reg_wdata;
               IDX_AMIN: alm_m_q    <= reg_wdata;
               IDX_HR:   tod_q.hr   <= reg_wdata;
               IDX_AHR:  alm_h_q    <= reg_wdata;
               IDX_WDAY: tod_q.wday <= reg_wdata;
               IDX_DATE: tod_q.date <= reg_wdata;
               IDX_MON:  tod_q.mon  <= reg_wdata;
               IDX_YEAR: tod_q.year <= reg_wdata;
               IDX_CTLA: ctla_q     <= reg_wdata[6:0];
               IDX_CTLB: ctlb_q     <= reg_wdata;
               default: ;
            endcase
         end
      end
   end

   always_comb begin
      case (reg_idx)
         IDX_SEC:  reg_rdata = tod_q.sec;
         IDX_ASEC: reg_rdata = alm_s_q;
         IDX_MIN:  reg_rdata = tod_q.min;
         IDX_AMIN: reg_rdata = alm_m_q;
         IDX_HR:   reg_rdata = tod_q.hr;
         IDX_AHR:  reg_rdata = alm_h_q;
         IDX_WDAY: reg_rdata = tod_q.wday;
         IDX_DATE: reg_rdata = tod_q.date;
         IDX_MON:  reg_rdata = tod_q.mon;
         IDX_YEAR: reg_rdata = tod_q.year;
         IDX_CTLA: reg_rdata = {uip, ctla_q};
         IDX_CTLB: reg_rdata = ctlb_q;
         default:  reg_rdata = 8'h00;
      endcase
   end
endmodule

// File: rtl/rtc_update_chk.sv
module rtc_update_chk #(
   parameter int LEAD_CYC = 4,
   parameter int UPD_CYC  = 8
) (
   input logic          clk,
   input logic          rst_n,
   input logic          uip,
   input logic          upd_done,
   input logic          alarm_evt,
   input logic          hold_bit,
   input logic          reg_wr,
   input rtc_pkg::tod_t tod
);
   localparam int TOTAL = LEAD_CYC + UPD_CYC;
   int unsigned run_len;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) run_len <= 0;
      else        run_len <= uip ? run_len + 1 : 0;
   end

   AST_BUSY_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n) run_len <= TOTAL); // R2
   AST_DONE_AFTER_BUSY: assert property (@(posedge clk) disable iff (!rst_n) upd_done |-> (!uip && $past(uip))); // R2
   AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) upd_done |=> !upd_done); // R4
   AST_TIME_FROZEN: assert property (@(posedge clk) disable iff (!rst_n) (uip && !$past(reg_wr)) |-> $stable(tod)); // R3
   AST_ALARM_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n) alarm_evt |-> upd_done); // R11
   AST_HOLD_STOPS: assert property (@(posedge clk) disable iff (!rst_n) hold_bit |=> !uip); // R9
endmodule

bind rtc_update_ctrl rtc_update_chk #(.LEAD_CYC(LEAD_CYC), .UPD_CYC(UPD_CYC)) u_chk (
   .clk(clk), .rst_n(rst_n), .uip(uip), .upd_done(upd_done), .alarm_evt(alarm_evt),
   .hold_bit(ctlb_q[7]), .reg_wr(reg_wr), .tod(tod_q)
);

// File: tb/tb_rtc_update_ctrl.sv
module tb_rtc_update_ctrl;
   localparam int LEAD = 4;
   localparam int UPD  = 8;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       sec_tick = 1'b0;
   logic [3:0] reg_idx = 4'd0;
   logic       reg_wr = 1'b0;
   logic [7:0] reg_wdata = 8'd0;
   logic [7:0] reg_rdata;
   logic       upd_done, alarm_evt;

   int n_chk = 0, n_bad = 0, done_cnt = 0;
   int ms, mm, mh, mwd, mdd, mmo, myr;
   bit mbin, m24;
   logic [7:0] al_s = 8'd0, al_m = 8'd0, al_h = 8'd0;

   always #4 clk = ~clk;

   rtc_update_ctrl #(.LEAD_CYC(LEAD), .UPD_CYC(UPD)) dut (
      .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick), .reg_idx(reg_idx),
      .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .upd_done(upd_done), .alarm_evt(alarm_evt)
   );

   always @(negedge clk) if (upd_done) done_cnt++;

   task automatic check(bit ok, string tag, int act, int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", tag, act, exp, $time);
      end
   endtask

   function automatic logic [7:0] enc(int v, bit b);
      return b ? 8'(v) : 8'(((v / 10) << 4) | (v % 10));
   endfunction

   function automatic logic [7:0] hbyte(int h, bit b, bit t24);
      logic [7:0] e;
      int hh;
      if (t24) return enc(h, b);
      hh = h % 12;
      if (hh == 0) hh = 12;
      e = enc(hh, b);
      return {(h >= 12), e[6:0]};
   endfunction

   function automatic int mdays(int mo, int y);
      if (mo == 2) return (y % 4 == 0) ? 29 : 28;
      if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
      return 31;
   endfunction

   task automatic wr(logic [3:0] i, logic [7:0] d);
      reg_idx = i; reg_wdata = d; reg_wr = 1'b1;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd(logic [3:0] i, output logic [7:0] d);
      reg_idx = i;
      #1;
      d = reg_rdata;
   endtask

   task automatic model_step();
      ms++;
      if (ms == 60) begin
         ms = 0; mm++;
         if (mm == 60) begin
            mm = 0; mh++;
            if (mh == 24) begin
               mh = 0;
               mwd = (mwd == 7) ? 1 : mwd + 1;
               mdd++;
               if (mdd > mdays(mmo, myr)) begin
                  mdd = 1; mmo++;
                  if (mmo == 13) begin
                     mmo = 1;
                     myr = (myr == 99) ? 0 : myr + 1;
                  end
               end
            end
         end
      end
   endtask

   task automatic load(bit b, bit t24, int s, int m, int h, int wd, int dd, int mo, int y);
      wr(4'd11, {1'b1, 4'b0, b, t24, 1'b0});
      wr(4'd0, enc(s, b)); wr(4'd2, enc(m, b)); wr(4'd4, hbyte(h, b, t24));
      wr(4'd6, enc(wd, b)); wr(4'd7, enc(dd, b)); wr(4'd8, enc(mo, b)); wr(4'd9, enc(y, b));
      wr(4'd11, {1'b0, 4'b0, b, t24, 1'b0});
      mbin = b; m24 = t24; ms = s; mm = m; mh = h; mwd = wd; mdd = dd; mmo = mo; myr = y;
   endtask

   task automatic cmp_all(string tag);
      logic [7:0] v;
      rd(4'd0, v); check(v == enc(ms, mbin), tag, v, enc(ms, mbin));
      rd(4'd2, v); check(v == enc(mm, mbin), tag, v, enc(mm, mbin));
      rd(4'd4, v); check(v == hbyte(mh, mbin, m24), tag, v, hbyte(mh, mbin, m24));
      rd(4'd6, v); check(v == enc(mwd, mbin), tag, v, enc(mwd, mbin));
      rd(4'd7, v); check(v == enc(mdd, mbin), tag, v, enc(mdd, mbin));
      rd(4'd8, v); check(v == enc(mmo, mbin), tag, v, enc(mmo, mbin));
      rd(4'd9, v); check(v == enc(myr, mbin), tag, v, enc(myr, mbin));
   endtask

   // one full update: timing (R2, R3, R4, R13), alarm (R11), then all fields
   task automatic do_update(string tag, bit extra);
      logic [7:0] old_s, v;
      bit exp_al;
      int d0;
      d0 = done_cnt;
      rd(4'd0, old_s);
      sec_tick = 1'b1;
      @(negedge clk);
      sec_tick = 1'b0;
      rd(4'd10, v); check(v[7] == 1'b1, "R2 busy rise", v, 8'h80 | v);
      if (extra) begin
         sec_tick = 1'b1; @(negedge clk); sec_tick = 1'b0; @(negedge clk);
         repeat (LEAD + UPD - 3) @(negedge clk);
      end else repeat (LEAD + UPD - 1) @(negedge clk);
      rd(4'd10, v); check(v[7] == 1'b1, "R2 busy hold", v[7], 1);
      check(upd_done == 1'b0, "R4 early", upd_done, 0);
      rd(4'd0, v); check(v == old_s, "R3 frozen", v, old_s);
      @(negedge clk);
      check(upd_done == 1'b1, "R4 pulse", upd_done, 1);
      rd(4'd10, v); check(v[7] == 1'b0, "R2 busy fall", v[7], 0);
      model_step();
      exp_al = (enc(ms, mbin) == al_s) && (enc(mm, mbin) == al_m) &&
               (hbyte(mh, mbin, m24) == al_h);
      check(alarm_evt == exp_al, "R11 alarm", alarm_evt, exp_al);
      cmp_all(tag);
      @(negedge clk);
      check(done_cnt == d0 + 1 && upd_done == 1'b0, "R13 single update", done_cnt - d0, 1);
   endtask

   initial begin
      logic [7:0] v;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset values, R12 unused indices
      for (int i = 0; i < 16; i++) begin
         int e;
         e = (i >= 6 && i <= 8) ? 1 : (i == 10) ? 8'h20 : (i == 11) ? 8'h02 : 0;
         rd(4'(i), v);
         check(v == 8'(e), (i >= 12) ? "R12 empty index" : "R1 reset", v, e);
      end
      check(upd_done == 1'b0 && alarm_evt == 1'b0, "R1 events", {upd_done, alarm_evt}, 0);

      // R12 busy bit not writable
      wr(4'd10, 8'hA0); rd(4'd10, v); check(v == 8'h20, "R12 flag read-only", v, 8'h20);

      // R5 / R7 seconds and minute carry, both encodings
      for (int b = 0; b < 2; b++) begin
         load(b[0], 1'b1, 0, 58, 7, 3, 12, 5, 30);
         for (int k = 0; k < 62; k++) do_update(b[0] ? "R7 binary" : "R5 seconds", k == 5);
      end
      // R5 hour sweep in 24h, R6 in 12h, both encodings
      for (int b = 0; b < 2; b++)
         for (int t = 0; t < 2; t++)
            for (int h = 0; h < 24; h++) begin
               load(b[0], t[0], 59, 59, h, 4, 15, 6, 21);
               do_update(t[0] ? "R5 hours" : "R6 twelve-hour", 1'b0);
            end
      // R8 month ends, leap and non-leap, both encodings
      for (int b = 0; b < 2; b++)
         for (int mo = 1; mo <= 12; mo++)
            for (int y = 23; y <= 24; y++) begin
               load(b[0], 1'b1, 59, 59, 23, 2, mdays(mo, y), mo, y);
               do_update("R8 month end", 1'b0);
            end
      load(1'b0, 1'b1, 59, 59, 23, 5, 31, 12, 99);
      do_update("R8 year wrap", 1'b0);
      for (int wd = 1; wd <= 7; wd++) begin
         load(1'b1, 1'b1, 59, 59, 23, wd, 10, 3, 22);
         do_update("R8 weekday", 1'b0);
      end
      load(1'b0, 1'b1, 59, 59, 23, 1, 28, 2, 24);
      do_update("R8 leap day", 1'b0);

      // R11 alarm match then no match
      load(1'b0, 1'b1, 55, 34, 12, 1, 1, 1, 0);
      al_s = 8'h56; al_m = 8'h34; al_h = 8'h12;
      wr(4'd1, al_s); wr(4'd3, al_m); wr(4'd5, al_h);
      do_update("R11 alarm time", 1'b0);
      do_update("R11 alarm time", 1'b0);

      // R9 hold blocks ticks
      begin
         int d0;
         logic [7:0] s0;
         d0 = done_cnt;
         rd(4'd0, s0);
         wr(4'd11, 8'h82);
         sec_tick = 1'b1; @(negedge clk); sec_tick = 1'b0;
         rd(4'd10, v); check(v[7] == 1'b0, "R9 no busy", v[7], 0);
         repeat (LEAD + UPD + 3) @(negedge clk);
         check(done_cnt == d0, "R9 no update", done_cnt - d0, 0);
         rd(4'd0, v); check(v == s0, "R9 time held", v, s0);
         // R9 abort mid-cycle
         wr(4'd11, 8'h02);
         sec_tick = 1'b1; @(negedge clk); sec_tick = 1'b0;
         rd(4'd10, v); check(v[7] == 1'b1, "R9 cycle started", v[7], 1);
         @(negedge clk);
         wr(4'd11, 8'h82);
         @(negedge clk);
         rd(4'd10, v); check(v[7] == 1'b0, "R9 abort", v[7], 0);
         repeat (LEAD + UPD + 3) @(negedge clk);
         check(done_cnt == d0, "R9 abort no update", done_cnt - d0, 0);
         rd(4'd0, v); check(v == s0, "R9 abort time held", v, s0);
         wr(4'd11, 8'h02);
         // R10 divider held in reset
         for (int k = 0; k < 2; k++) begin
            wr(4'd10, k ? 8'h70 : 8'h60);
            rd(4'd10, v); check(v == (k ? 8'h70 : 8'h60), "R10 selector stored", v, k ? 8'h70 : 8'h60);
            sec_tick = 1'b1; @(negedge clk); sec_tick = 1'b0;
            rd(4'd10, v); check(v[7] == 1'b0, "R10 no busy", v[7], 0);
            repeat (LEAD + UPD + 3) @(negedge clk);
            check(done_cnt == d0, "R10 no update", done_cnt - d0, 0);
            rd(4'd0, v); check(v == s0, "R10 time held", v, s0);
         end
         wr(4'd10, 8'h20);
         do_update("R10 resumed", 1'b0);
      end

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog run did not finish actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule